// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Control

This block owns the exception and control fields of a 32-bit floating-point status register. The arithmetic datapath reports raw IEEE exception conditions (invalid, overflow, underflow, divide-by-zero, inexact) into a pending-flag register. On a commit strobe the pending flags are merged into the current-exception field. The block then checks the result against the trap-enable field. If an enabled exception is present, it requests a trap and marks the trap type as an IEEE exception. Otherwise it folds the current exceptions into the accrued field.

Software can load the register through a masked write that leaves the trap-type field and the reserved bits untouched. The rounding-direction field is decoded continuously into a one-hot rounding-mode output for the datapath. A separate strobe clears the pending raw flags between operations.

Top module: `fsr_ctl`

## Requirements
- R1: After reset, `fsr_o` is 0, `pend_o` is 0, `trap_o` is 0 and `rnd_o` selects nearest (4'b0001).
- R2: When `raw_we_i` is high, `raw_flags_i` is ORed into the pending flags, which appear on `pend_o` one cycle later. Bit order is 4 invalid, 3 overflow, 2 underflow, 1 divide-by-zero, 0 inexact.
- R3: When `chk_i` is high and the pending flags are nonzero, the current-exception field `fsr_o[4:0]` becomes its old value ORed with the pending flags in the next cycle.
- R4: If that new current-exception value ANDed with the trap-enable field `fsr_o[27:23]` is nonzero, the following happens in the next cycle:
  - `trap_o` is high for exactly that cycle.
  - The trap-type field `fsr_o[16:14]` becomes 3'b001.
  - The accrued field `fsr_o[9:5]` is left unchanged.
- R5: If no enabled exception is present, the new current-exception value is ORed into the accrued field `fsr_o[9:5]` and `trap_o` stays low.
- R6: A commit while the pending flags are zero changes nothing: `fsr_o` holds and `trap_o` stays low.
- R7: `rnd_o` is one-hot from `fsr_o[31:30]`: 00 gives bit 0 (nearest-even), 01 gives bit 1 (toward zero), 10 gives bit 2 (toward +inf), 11 gives bit 3 (toward -inf).
- R8: When `ld_i` is high, the register becomes `(ld_data_i & 32'hCF8003FF) | (fsr_o & ~32'hCF8003FF)` in the next cycle. The trap-type field and the reserved bits are therefore kept.
- R9: `raw_clr_i` zeroes the pending flags in the next cycle and takes priority over `raw_we_i` in the same cycle.
- R10: When `ld_i` and `chk_i` are high in the same cycle, the load is applied and the commit is discarded: no trap and no exception merge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| raw_we_i | input | 1 | Record raw exception flags |
| raw_flags_i | input | 5 | Raw flags {nv,of,uf,dz,nx} |
| raw_clr_i | input | 1 | Clear pending raw flags |
| chk_i | input | 1 | Commit pending flags to the register |
| ld_i | input | 1 | Masked software load |
| ld_data_i | input | 32 | Load value |
| fsr_o | output | 32 | Status register contents |
| pend_o | output | 5 | Pending raw flags |
| trap_o | output | 1 | Trap request pulse |
| rnd_o | output | 4 | One-hot rounding mode |

## Verification
A software load and an exception commit can land in the same cycle. The load must win and the commit must leave no trace. The bench provokes this with nonzero pending flags and every trap enable set. It then checks that `trap_o` stays low and that the register equals exactly the masked load result.

Raw-flag recording, clearing and committing can also coincide. A commit issued together with new raw flags is judged against the pending value from before that edge. A clear issued together with a set is judged as a clear.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int REG_W    = 32;
  localparam int EXC_W    = 5;
  localparam int CEXC_LSB = 0;
  localparam int AEXC_LSB = 5;
  localparam int FTT_LSB  = 14;
  localparam int FTT_W    = 3;
  localparam int TEM_LSB  = 23;
  localparam int RD_LSB   = 30;
  localparam int RD_W     = 2;
  localparam int RND_N    = 1 << RD_W;
  localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;

  function automatic logic [REG_W-1:0] field_mask(int lsb, int w);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < w; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  // writable on load: rounding, trap enables, accrued, current
  localparam logic [REG_W-1:0] WR_MASK = field_mask(RD_LSB, RD_W) |
                                         field_mask(TEM_LSB, EXC_W) |
                                         field_mask(AEXC_LSB, EXC_W) |
                                         field_mask(CEXC_LSB, EXC_W);
endpackage

// File: rtl/fsr_raw_pend.sv
module fsr_raw_pend #(
  parameter int EXC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [EXC_W-1:0] flags_i,
  input  logic             clr_i,
  output logic [EXC_W-1:0] pend_o
);
  logic [EXC_W-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= '0;
    else if (clr_i) pend_q <= '0;
    else if (set_i) pend_q <= pend_q | flags_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/fsr_exc_eval.sv
module fsr_exc_eval #(
  parameter int EXC_W = 5
) (
  input  logic [EXC_W-1:0] cexc_i,
  input  logic [EXC_W-1:0] tem_i,
  input  logic [EXC_W-1:0] pend_i,
  output logic [EXC_W-1:0] cexc_nxt_o,
  output logic             any_o,
  output logic             hit_o
);
  logic [EXC_W-1:0] en_hit;

  assign cexc_nxt_o = cexc_i | pend_i;
  assign any_o      = |pend_i;

  for (genvar g = 0; g < EXC_W; g++) begin : g_hit
    assign en_hit[g] = cexc_nxt_o[g] & tem_i[g];
  end

  assign hit_o = |en_hit;
endmodule

// File: rtl/fsr_rnd_dec.sv
module fsr_rnd_dec #(
  parameter int RD_W = 2,
  localparam int RND_N = 1 << RD_W
) (
  input  logic [RD_W-1:0]  rd_i,
  output logic [RND_N-1:0] rnd_o
);
  for (genvar g = 0; g < RND_N; g++) begin : g_dec
    assign rnd_o[g] = (rd_i == RD_W'(g));
  end
endmodule

// File: rtl/fsr_ctl.sv
module fsr_ctl
  import fsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_we_i,
  input  logic [EXC_W-1:0] raw_flags_i,
  input  logic             raw_clr_i,
  input  logic             chk_i,
  input  logic             ld_i,
  input  logic [REG_W-1:0] ld_data_i,
  output logic [REG_W-1:0] fsr_o,
  output logic [EXC_W-1:0] pend_o,
  output logic             trap_o,
  output logic [RND_N-1:0] rnd_o
);
  logic [REG_W-1:0] fsr_q, fsr_d;
  logic             trap_q, trap_d;
  logic [EXC_W-1:0] pend;
  logic [EXC_W-1:0] cexc_nxt;
  logic             any_pend, hit;

  fsr_raw_pend #(.EXC_W(EXC_W)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (raw_we_i),
    .flags_i(raw_flags_i),
    .clr_i  (raw_clr_i),
    .pend_o (pend)
  );

  fsr_exc_eval #(.EXC_W(EXC_W)) u_eval (
    .cexc_i    (fsr_q[CEXC_LSB +: EXC_W]),
    .tem_i     (fsr_q[TEM_LSB +: EXC_W]),
    .pend_i    (pend),
    .cexc_nxt_o(cexc_nxt),
    .any_o     (any_pend),
    .hit_o     (hit)
  );

  fsr_rnd_dec #(.RD_W(RD_W)) u_rnd (
    .rd_i (fsr_q[RD_LSB +: RD_W]),
    .rnd_o(rnd_o)
  );

  always_comb begin
    fsr_d  = fsr_q;
    trap_d = 1'b0;
    if (ld_i) begin
      fsr_d = (ld_data_i & WR_MASK) | (fsr_q & ~WR_MASK);
    end else if (chk_i && any_pend) begin
      fsr_d[CEXC_LSB +: EXC_W] = cexc_nxt;
      if (hit) begin
        fsr_d[FTT_LSB +: FTT_W] = FTT_IEEE;
        trap_d = 1'b1;
      end else begin
        fsr_d[AEXC_LSB +: EXC_W] = fsr_q[AEXC_LSB +: EXC_W] | cexc_nxt;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsr_q  <= '0;
      trap_q <= 1'b0;
    end else begin
      fsr_q  <= fsr_d;
      trap_q <= trap_d;
    end
  end

  assign fsr_o  = fsr_q;
  assign pend_o = pend;
  assign trap_o = trap_q;
endmodule

// File: rtl/fsr_ctl_chk.sv
module fsr_ctl_chk
  import fsr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             raw_clr_i,
  input logic             chk_i,
  input logic             ld_i,
  input logic [REG_W-1:0] fsr_o,
  input logic [EXC_W-1:0] pend_o,
  input logic             trap_o,
  input logic [RND_N-1:0] rnd_o
);
  AST_TRAP_FTT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> fsr_o[FTT_LSB +: FTT_W] == FTT_IEEE); // R4

  AST_TRAP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(chk_i) && !$past(ld_i)); // R4

  AST_TRAP_NO_ACCRUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $stable(fsr_o[AEXC_LSB +: EXC_W])); // R4

  AST_ACCRUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_i && !ld_i && pend_o != '0) |=>
      trap_o || ((fsr_o[AEXC_LSB +: EXC_W] & $past(pend_o)) == $past(pend_o))); // R5

  AST_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_i && !ld_i && pend_o == '0) |=> $stable(fsr_o) && !trap_o); // R6

  AST_RND_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rnd_o) == 1); // R7

  AST_LOAD_KEEP_FTT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> $stable(fsr_o[FTT_LSB +: FTT_W])); // R8

  AST_CLR_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_clr_i |=> pend_o == '0); // R9

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && chk_i) |=> !trap_o); // R10
endmodule

bind fsr_ctl fsr_ctl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .raw_clr_i(raw_clr_i),
  .chk_i    (chk_i),
  .ld_i     (ld_i),
  .fsr_o    (fsr_o),
  .pend_o   (pend_o),
  .trap_o   (trap_o),
  .rnd_o    (rnd_o)
);

// File: tb/sim_fsr_ctl.sv
`timescale 1ns/1ps
module sim_fsr_ctl;
  localparam logic [31:0] MASK = 32'hCF80_03FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raw_we = 1'b0;
  logic [4:0]  raw_flags = '0;
  logic        raw_clr = 1'b0;
  logic        chk = 1'b0;
  logic        ld = 1'b0;
  logic [31:0] ld_data = '0;
  logic [31:0] fsr;
  logic [4:0]  pend;
  logic        trap;
  logic [3:0]  rnd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_fsr;
  logic [4:0]  m_pend;
  logic        m_trap;

  always #4 clk = ~clk;

  fsr_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .raw_we_i(raw_we), .raw_flags_i(raw_flags),
    .raw_clr_i(raw_clr), .chk_i(chk), .ld_i(ld), .ld_data_i(ld_data),
    .fsr_o(fsr), .pend_o(pend), .trap_o(trap), .rnd_o(rnd)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    check(req, "fsr", fsr, m_fsr);
    check(req, "pend", {27'd0, pend}, {27'd0, m_pend});
    check(req, "trap", {31'd0, trap}, {31'd0, m_trap});
    check(req, "rnd", {28'd0, rnd}, 32'd1 << m_fsr[31:30]);
  endtask

  // model next state from current inputs, advance one edge, release inputs
  task automatic step();
    logic [31:0] f;
    logic [4:0]  p, c;
    logic        t;
    p = raw_clr ? 5'd0 : (raw_we ? (m_pend | raw_flags) : m_pend);
    f = m_fsr;
    t = 1'b0;
    if (ld) begin
      f = (ld_data & MASK) | (m_fsr & ~MASK);
    end else if (chk && m_pend != 0) begin
      c = m_fsr[4:0] | m_pend;
      f[4:0] = c;
      if ((c & m_fsr[27:23]) != 0) begin
        f[16:14] = 3'b001;
        t = 1'b1;
      end else begin
        f[9:5] = m_fsr[9:5] | c;
      end
    end
    @(negedge clk);
    m_fsr = f; m_pend = p; m_trap = t;
    raw_we = 0; raw_flags = 0; raw_clr = 0; chk = 0; ld = 0; ld_data = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0] tems [7];
    tems = '{5'h00, 5'h01, 5'h02, 5'h04, 5'h08, 5'h10, 5'h1F};
    m_fsr = 0; m_pend = 0; m_trap = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");

    // sweep enables x pending patterns
    for (int ti = 0; ti < 7; ti++) begin
      for (int p = 1; p < 32; p++) begin
        ld = 1; ld_data = {p[1:0], 2'b00, tems[ti], 23'd0};
        step(); compare("R8"); compare("R7");
        raw_we = 1; raw_flags = p[4:0];
        step(); compare("R2");
        chk = 1;
        step();
        if (m_trap) compare("R4"); else compare("R5");
        compare("R3");
        raw_clr = 1;
        step(); compare("R9");
      end
    end

    // sticky current exception triggers trap with new unrelated flag
    ld = 1; ld_data = {2'b01, 2'b00, 5'h10, 18'd0, 5'h10};
    step(); compare("R8");
    raw_we = 1; raw_flags = 5'h01;
    step();
    chk = 1;
    step(); compare("R4");
    check("R4", "trap_sticky", {31'd0, trap}, 32'd1);

    // load all ones keeps trap type and reserved bits
    ld = 1; ld_data = 32'hFFFF_FFFF;
    step(); compare("R8");
    check("R8", "ones", fsr, 32'hCF80_43FF);
    ld = 1; ld_data = 32'h0;
    step(); compare("R8");
    check("R8", "zeros", fsr, 32'h0000_4000);

    // commit with nothing pending
    raw_clr = 1;
    step();
    ld = 1; ld_data = {2'b10, 2'b00, 5'h00, 18'd0, 5'h0A};
    step();
    chk = 1;
    step(); compare("R6");

    // set and clear together: clear wins
    raw_we = 1; raw_flags = 5'h15;
    step(); compare("R2");
    raw_we = 1; raw_flags = 5'h0A; raw_clr = 1;
    step(); compare("R9");

    // commit in same cycle as new raw flags uses the old pending value
    raw_we = 1; raw_flags = 5'h04;
    step();
    raw_we = 1; raw_flags = 5'h10; chk = 1;
    step(); compare("R3"); compare("R2");

    // load and commit together
    raw_clr = 1;
    step();
    ld = 1; ld_data = {2'b11, 2'b00, 5'h1F, 23'd0};
    step();
    raw_we = 1; raw_flags = 5'h1F;
    step();
    ld = 1; chk = 1; ld_data = {2'b00, 2'b00, 5'h1F, 18'd0, 5'h02};
    step(); compare("R10");
    check("R10", "trap_collide", {31'd0, trap}, 32'd0);
    chk = 1;
    step(); compare("R4");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule